// File: doc/BRIEF.md
# Two-Stage Logic Analyzer Trigger

This block decides when a 16-channel logic analyzer fires. Every clock in which the sample-valid input is high, it tests the incoming 16-bit word against two independent match stages, A and B. Each stage holds five 16-bit channel masks:

- rising edge
- falling edge
- either edge
- must read one
- must read zero

A combine operation then merges the two stage results into a single trigger pulse. One of the combine operations is a sequence in which stage A must match first and stage B afterwards.

Masks are loaded one byte at a time through a 16-bit configuration word. The word carries a 7-bit byte address and a data byte. A byte is committed by pulsing the top bit: the word is written with that bit clear, then with it set, then with it clear again. The combine operation has its own write port. After the trigger fires once, the unit stays silent until it is re-armed.

Top module: `trig2stage`

## Requirements
- R1: A configuration byte is committed only on a write whose bit 15 is 1 when the previous configuration write had bit 15 at 0. Writes with bit 15 at 0, and repeated writes with bit 15 held at 1, change no mask.
- R2: Configuration word bits 14:8 are the byte address and bits 7:0 are the data. Address bit 6 selects stage B (offset 0x40) or stage A (offset 0x00). Within a stage, byte offsets 0..9 hold the five masks as low/high byte pairs, in this order: rising (0,1), falling (2,3), either edge (4,5), must-be-one (6,7), must-be-zero (8,9). Other offsets are accepted and ignored.
- R3: Within one stage the edge conditions of all channels are OR'd. A rising edge is previous 0 and current 1; a falling edge is previous 1 and current 0; the either-edge mask accepts both. A stage with no edge bits set needs no edge.
- R4: The level part of a stage holds only when every must-be-one channel reads 1 and every must-be-zero channel reads 0. With no level bits set, the level part holds. A stage matches when its level part and its edge part both hold.
- R5: Edges are taken against the previous valid sample. No edge is seen on the first valid sample after reset or after a re-arm.
- R6: Cycles with sample-valid low neither match nor update the previous-sample register.
- R7: The combine word selects how the stages merge: 0x1000 A only, 0x2000 B only, 0x3000 A or B, 0x4000 A and B (same sample), 0x8000 A then B. Any other value never triggers.
- R8: In A-then-B mode, a match of stage A sets a sticky flag. The trigger fires on a later valid sample that matches stage B. The flag is cleared by re-arm.
- R9: The trigger output is a one-cycle pulse, high in the cycle after the firing sample's clock edge. Once it has fired, further matches are ignored until `arm` is pulsed.
- R10: After reset the output is low, all masks are zero, the combine operation is A only, and the unit is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Re-arm pulse; clears history, sequence flag and fired state |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_word | input | 16 | Strobe bit 15, byte address 14:8, data 7:0 |
| op_we | input | 1 | Combine operation write enable |
| op_word | input | 16 | Combine operation code |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 16 | Sample word, one bit per channel |
| trig | output | 1 | Single-cycle trigger pulse |

## Verification
The hardest case to reach is the A-then-B sequence. It needs the sticky flag to be set by one sample and then consumed by a different, later one. The stimulus therefore orders samples on purpose:
- B alone before A, which must not fire;
- one sample matching both stages, which must not fire until a second matching sample arrives;
- a re-arm between the A sample and the B sample, which must erase the flag.

The strobe handshake is also driven by hand with malformed sequences: a missing strobe, and a strobe held high across two writes. The resulting masks are then read back through trigger behaviour.

// File: rtl/trig2stage.sv
module trig2stage (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        cfg_we,
  input  logic [15:0] cfg_word,
  input  logic        op_we,
  input  logic [15:0] op_word,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  output logic        trig
);
  localparam int RISE = 0;
  localparam int FALL = 1;
  localparam int ANY  = 2;
  localparam int ONE  = 3;
  localparam int ZERO = 4;
  localparam logic [15:0] OP_A    = 16'h1000;
  localparam logic [15:0] OP_B    = 16'h2000;
  localparam logic [15:0] OP_OR   = 16'h3000;
  localparam logic [15:0] OP_AND  = 16'h4000;
  localparam logic [15:0] OP_THEN = 16'h8000;

  logic [1:0][4:0][15:0] msk;
  logic [15:0] op_q, prev;
  logic stb_q, have_prev, a_seen, done;
  logic [1:0] hit;
  logic fire;

  wire        commit = cfg_we & cfg_word[15] & ~stb_q;
  wire        csel   = cfg_word[14];
  wire [5:0]  coff   = cfg_word[13:8];
  wire [2:0]  cidx   = coff[3:1];
  wire [15:0] rise_w = smp_data & ~prev;
  wire [15:0] fall_w = ~smp_data & prev;

  for (genvar s = 0; s < 2; s++) begin : g_stage
    wire [15:0] m_r = msk[s][RISE];
    wire [15:0] m_f = msk[s][FALL];
    wire [15:0] m_a = msk[s][ANY];
    wire [15:0] m_1 = msk[s][ONE];
    wire [15:0] m_0 = msk[s][ZERO];
    wire edge_req = |(m_r | m_f | m_a);
    wire edge_ok  = have_prev & (|((m_r & rise_w) | (m_f & fall_w) | (m_a & (rise_w | fall_w))));
    wire lvl_ok   = (&(~m_1 | smp_data)) & (&(~m_0 | ~smp_data));
    assign hit[s] = smp_valid & lvl_ok & (edge_req ? edge_ok : 1'b1);
  end

  always_comb begin
    case (op_q)
      OP_A:    fire = hit[0];
      OP_B:    fire = hit[1];
      OP_OR:   fire = hit[0] | hit[1];
      OP_AND:  fire = hit[0] & hit[1];
      OP_THEN: fire = a_seen & hit[1];
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk       <= '0;
      stb_q     <= 1'b0;
      op_q      <= OP_A;
      prev      <= '0;
      have_prev <= 1'b0;
      a_seen    <= 1'b0;
      done      <= 1'b0;
      trig      <= 1'b0;
    end else begin
      if (cfg_we) stb_q <= cfg_word[15];
      if (commit && coff < 6'd10) begin
        if (coff[0]) msk[csel][cidx][15:8] <= cfg_word[7:0];
        else         msk[csel][cidx][7:0]  <= cfg_word[7:0];
      end
      if (op_we) op_q <= op_word;
      if (arm) begin
        have_prev <= 1'b0;
        a_seen    <= 1'b0;
        done      <= 1'b0;
        trig      <= 1'b0;
      end else begin
        trig <= fire & ~done;
        if (fire) done <= 1'b1;
        if (smp_valid) begin
          prev      <= smp_data;
          have_prev <= 1'b1;
        end
        if (op_q == OP_THEN && hit[0]) a_seen <= 1'b1;
      end
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  a_r9_hold_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> !trig);
  a_r6_no_trig_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !trig);
  a_r8_then_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_THEN && !a_seen) |=> !trig);
  a_r7_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_A && op_q != OP_B && op_q != OP_OR && op_q != OP_AND && op_q != OP_THEN) |=> !trig);
  a_r1_no_commit_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || !cfg_word[15]) |=> $stable(msk));
endmodule

// File: tb/trig2stage_bench.sv
module trig2stage_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_word = '0;
  logic op_we = 1'b0;
  logic [15:0] op_word = '0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic trig;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig2stage u_trig2stage (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .cfg_we(cfg_we), .cfg_word(cfg_word),
    .op_we(op_we), .op_word(op_word),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .trig(trig)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: trig=%b expected %b", req, got, exp);
    end
  endtask

  task automatic cfgraw(input logic [15:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_word = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_word = {1'b0, a, d};
    @(negedge clk); cfg_word[15] = 1'b1;
    @(negedge clk); cfg_word[15] = 1'b0;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic setmask(input bit stage_b, input int idx, input logic [15:0] v);
    logic [6:0] base;
    base = (stage_b ? 7'h40 : 7'h00) + 7'(idx * 2);
    cfg(base, v[7:0]);
    cfg(base + 7'd1, v[15:8]);
  endtask

  task automatic clear_all();
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++) setmask(s[0], i, 16'h0000);
  endtask

  task automatic setop(input logic [15:0] w);
    @(negedge clk); op_we = 1'b1; op_word = w;
    @(negedge clk); op_we = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic expect_smp(input string req, input logic [15:0] d, input logic e);
    @(negedge clk); smp_valid = 1'b1; smp_data = d;
    @(posedge clk); #1;
    smp_valid = 1'b0;
    check(req, trig, e);
  endtask

  task automatic t_reset();
    check("R10 reset low", trig, 1'b0);
    expect_smp("R10 empty stage A fires", 16'h1234, 1'b1);
    expect_smp("R9 ignored until rearm", 16'h1234, 1'b0);
  endtask

  task automatic t_strobe();
    clear_all();
    setmask(1'b0, 3, 16'h8000);
    do_arm();
    expect_smp("R4 one-bit unmet", 16'h0000, 1'b0);
    cfgraw({1'b0, 7'h08, 8'h01});
    do_arm();
    expect_smp("R1 no strobe no commit", 16'h8001, 1'b1);
    cfgraw({1'b1, 7'h08, 8'h00});
    cfgraw({1'b1, 7'h08, 8'h01});
    cfgraw({1'b0, 7'h08, 8'h00});
    do_arm();
    expect_smp("R1 held strobe no commit", 16'h8001, 1'b1);
    cfg(7'h08, 8'h01);
    do_arm();
    expect_smp("R1 strobe commits zero-bit", 16'h8001, 1'b0);
    expect_smp("R4 both levels met", 16'h8000, 1'b1);
  endtask

  task automatic t_edges();
    clear_all();
    setmask(1'b0, 0, 16'h0002);
    setmask(1'b0, 1, 16'h0004);
    setmask(1'b0, 2, 16'h0008);
    do_arm();
    expect_smp("R5 first sample no edge", 16'h0002, 1'b0);
    expect_smp("R3 falling ch1 not armed", 16'h0000, 1'b0);
    expect_smp("R3 rising ch1", 16'h0002, 1'b1);
    do_arm();
    expect_smp("R5 first after rearm", 16'h0004, 1'b0);
    expect_smp("R3 falling ch2", 16'h0000, 1'b1);
    do_arm();
    expect_smp("R5 first after rearm", 16'h0008, 1'b0);
    expect_smp("R3 any-edge ch3 falling", 16'h0000, 1'b1);
  endtask

  task automatic t_invalid();
    clear_all();
    setmask(1'b0, 0, 16'h0001);
    do_arm();
    expect_smp("R5 first sample", 16'h0000, 1'b0);
    @(negedge clk); smp_data = 16'h0001;
    @(posedge clk); #1;
    check("R6 invalid ignored", trig, 1'b0);
    expect_smp("R6 prev not updated", 16'h0000, 1'b0);
    expect_smp("R3 rising after invalid", 16'h0001, 1'b1);
  endtask

  task automatic t_level();
    clear_all();
    setmask(1'b0, 3, 16'h0010);
    setmask(1'b0, 4, 16'h0020);
    do_arm();
    expect_smp("R4 zero-bit violated", 16'h0030, 1'b0);
    expect_smp("R4 one-bit violated", 16'h0000, 1'b0);
    expect_smp("R4 levels met", 16'h0010, 1'b1);
    setmask(1'b0, 0, 16'h0001);
    do_arm();
    expect_smp("R4 edge plus level first", 16'h0000, 1'b0);
    expect_smp("R4 edge without level", 16'h0001, 1'b0);
    expect_smp("R4 back low", 16'h0010, 1'b0);
    expect_smp("R4 edge with level", 16'h0011, 1'b1);
  endtask

  task automatic t_combine();
    clear_all();
    setmask(1'b0, 0, 16'h0001);
    setmask(1'b1, 0, 16'h0002);
    setop(16'h4000);
    do_arm();
    expect_smp("R7 and: first", 16'h0000, 1'b0);
    expect_smp("R7 and: A only", 16'h0001, 1'b0);
    expect_smp("R7 and: low", 16'h0000, 1'b0);
    expect_smp("R2 and: B only", 16'h0002, 1'b0);
    expect_smp("R7 and: low", 16'h0000, 1'b0);
    expect_smp("R7 and: both", 16'h0003, 1'b1);
    setop(16'h2000);
    do_arm();
    expect_smp("R7 B: first", 16'h0000, 1'b0);
    expect_smp("R2 B-only rising ch1", 16'h0002, 1'b1);
    setop(16'h3000);
    do_arm();
    expect_smp("R7 or: first", 16'h0000, 1'b0);
    expect_smp("R7 or: A", 16'h0001, 1'b1);
    setop(16'h5000);
    do_arm();
    expect_smp("R7 bad code: first", 16'h0000, 1'b0);
    expect_smp("R7 bad code silent", 16'h0003, 1'b0);
    setop(16'h1000);
    do_arm();
    expect_smp("R7 A: first", 16'h0000, 1'b0);
    expect_smp("R7 A ignores B", 16'h0002, 1'b0);
    expect_smp("R7 A: low", 16'h0000, 1'b0);
    expect_smp("R7 A fires", 16'h0001, 1'b1);
  endtask

  task automatic t_then();
    clear_all();
    setmask(1'b0, 3, 16'h0100);
    setmask(1'b1, 3, 16'h0200);
    setop(16'h8000);
    do_arm();
    expect_smp("R8 B before A", 16'h0200, 1'b0);
    expect_smp("R8 A sets flag", 16'h0100, 1'b0);
    expect_smp("R8 B after A", 16'h0200, 1'b1);
    expect_smp("R9 no refire", 16'h0200, 1'b0);
    do_arm();
    expect_smp("R8 same sample A+B", 16'h0300, 1'b0);
    expect_smp("R8 later B fires", 16'h0300, 1'b1);
    do_arm();
    expect_smp("R8 A sets flag", 16'h0100, 1'b0);
    do_arm();
    expect_smp("R8 rearm clears flag", 16'h0200, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_strobe();
    t_edges();
    t_invalid();
    t_level();
    t_combine();
    t_then();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule